// File: doc/BRIEF.md
# Burst Transfer Address Generator

This block sits inside a system-bus master and produces, one beat at a time, the address and the transfer-type code of a burst. A burst is launched with a one-cycle start strobe that carries a start address, a transfer size (byte, halfword or word) and a burst kind. The kind is a single transfer, an incrementing burst of undefined length, or an incrementing or wrapping burst of 4, 8 or 16 beats. The current beat is taken by the slave on every clock edge where ready is high. While ready is low, the block holds the address and the type unchanged.

A wrapping burst stays inside an aligned block whose size is the beat count times the transfer size. When it reaches the end of that block it continues from the block start. An incrementing burst never crosses a 1 KB address boundary inside a single sequence. A beat that lands on such a boundary is issued as a fresh non-sequential transfer, and the burst then goes on. An undefined-length burst runs until the master raises a stop request on an accepted beat. A start address that does not match the transfer size is rejected with an error pulse, and no beat is issued.

Top module: `burst_addr_gen`

## Requirements
- R1: During and right after synchronous reset, `trans_o` is 00 (idle), `addr_o` is 0, and `done_o` and `err_o` are 0.
- R2: A start strobe seen while idle, with a legal and aligned request, makes the next cycle show `addr_o` equal to the start address and `trans_o` equal to 10 (non-sequential). Size codes are 0 for byte, 1 for halfword and 2 for word.
- R3: In an incrementing burst, each accepted beat advances the address by 1, 2 or 4 for byte, halfword or word. A beat whose address has bits [9:0] all zero is issued as 10 and not as 11, so that no sequential run crosses a 1 KB boundary.
- R4: Every beat after the first beat of a burst is issued as 11 (sequential), except for the boundary case in R3. Kind codes are 0 single, 1 undefined incrementing, 2/4/6 wrapping 4/8/16, and 3/5/7 incrementing 4/8/16.
- R5: A wrapping burst keeps every address inside the aligned block of beats×size bytes that holds the start address. After the last byte of the block it steps to the block start.
- R6: While a beat is pending and `ready_i` is low, `addr_o` and `trans_o` do not change.
- R7: A single transfer issues one beat, and a fixed burst issues exactly its beat count. An undefined burst ends on the beat accepted with `stop_i` high. After the last accepted beat, `trans_o` returns to 00.
- R8: `done_o` is high in exactly the cycle in which the last beat of a burst is accepted (beat pending and `ready_i` high), and low otherwise.
- R9: A start strobe while a burst is in progress has no effect on the addresses, types or length of the running burst.
- R10: A halfword start with bit 0 set, a word start with bits [1:0] nonzero, or size code 3 raises `err_o` for one cycle in the next cycle, and `trans_o` stays 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, sampled while idle |
| start_addr_i | input | AW | First address of the burst |
| size_i | input | 2 | Transfer size code |
| kind_i | input | 3 | Burst kind code |
| stop_i | input | 1 | Ends an undefined-length burst on the accepted beat |
| ready_i | input | 1 | Slave accepts the current beat |
| addr_o | output | AW | Address of the current beat |
| trans_o | output | 2 | Transfer type: 00 idle, 10 non-sequential, 11 sequential |
| done_o | output | 1 | Last beat accepted this cycle |
| err_o | output | 1 | Start request rejected |

## Verification
The bench runs every burst kind. Word wrapping bursts start in the middle of a block, so a wrong block mask shows up as an address that leaves the block. Halfword and byte wrapping bursts start at odd offsets, which separates a size-scaled mask from a fixed one. Incrementing bursts that start just below a 1 KB line, one fixed and one of undefined length, separate the boundary restart from plain sequencing. Random ready patterns check that beats hold on wait states. Start strobes in the middle of a burst, carrying a different kind and address, must leave the burst untouched. Misaligned halfword and word starts and the reserved size code must give an error with no beat.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [2:0] KD_SINGLE = 3'd0;
  localparam logic [2:0] KD_UNDEF  = 3'd1;
endpackage

// File: rtl/burst_kind_decode.sv
`timescale 1ns/1ps
// Turns kind and size codes into beat count, step, wrap mask and legality.
module burst_kind_decode #(
  parameter int CW = 5,
  parameter int MW = 7
) (
  input  logic [2:0]    kind,
  input  logic [1:0]    size,
  output logic [CW-1:0] beats,
  output logic          undef,
  output logic          wrap,
  output logic [2:0]    inc,
  output logic [MW-1:0] mask,
  output logic          size_bad
);
  import burst_pkg::*;

  always_comb begin
    case (kind[2:1])
      2'd0:    beats = CW'(1);
      2'd1:    beats = CW'(4);
      2'd2:    beats = CW'(8);
      default: beats = CW'(16);
    endcase
  end

  assign undef = (kind == KD_UNDEF);
  assign wrap  = (kind[2:1] != 2'd0) && !kind[0];

  always_comb begin
    size_bad = 1'b0;
    case (size)
      SZ_BYTE: inc = 3'd1;
      SZ_HALF: inc = 3'd2;
      SZ_WORD: inc = 3'd4;
      default: begin
        inc      = 3'd0;
        size_bad = 1'b1;
      end
    endcase
  end

  assign mask = (MW'(beats) * MW'(inc)) - MW'(1);
endmodule

// File: rtl/burst_align_check.sv
`timescale 1ns/1ps
// Flags a start address whose low bits disagree with the transfer size.
module burst_align_check (
  input  logic [1:0] low_addr,
  input  logic [1:0] size,
  input  logic       size_bad,
  output logic       bad
);
  import burst_pkg::*;

  always_comb begin
    case (size)
      SZ_HALF: bad = low_addr[0];
      SZ_WORD: bad = |low_addr;
      default: bad = size_bad;
    endcase
  end
endmodule

// File: rtl/burst_step.sv
`timescale 1ns/1ps
// Next beat address: bits under the wrap mask take the sum, the rest keep the
// block base; incrementing bursts take the full sum and report boundary hits.
module burst_step #(
  parameter int AW = 32,
  parameter int MW = 7,
  parameter int BB = 10
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    inc,
  input  logic          wrap,
  input  logic [MW-1:0] mask,
  output logic [AW-1:0] next,
  output logic          bnd_hit
);
  logic [AW-1:0] sum;
  assign sum = addr + AW'(inc);

  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i < MW) begin : g_low
      assign next[i] = (wrap && !mask[i]) ? addr[i] : sum[i];
    end else begin : g_high
      assign next[i] = wrap ? addr[i] : sum[i];
    end
  end

  assign bnd_hit = !wrap && (next[BB-1:0] == '0);
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen #(
  parameter int AW = 32,
  parameter int BB = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    kind_i,
  input  logic          stop_i,
  input  logic          ready_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    trans_o,
  output logic          done_o,
  output logic          err_o
);
  import burst_pkg::*;

  localparam int MAXB = 16;
  localparam int CW   = $clog2(MAXB) + 1;
  localparam int MW   = $clog2(MAXB * 4) + 1;

  // decode of the incoming request
  logic [CW-1:0] d_beats;
  logic          d_undef, d_wrap, d_size_bad, d_misalign;
  logic [2:0]    d_inc;
  logic [MW-1:0] d_mask;

  burst_kind_decode #(.CW(CW), .MW(MW)) u_dec (
    .kind(kind_i), .size(size_i), .beats(d_beats), .undef(d_undef),
    .wrap(d_wrap), .inc(d_inc), .mask(d_mask), .size_bad(d_size_bad)
  );

  burst_align_check u_align (
    .low_addr(start_addr_i[1:0]), .size(size_i),
    .size_bad(d_size_bad), .bad(d_misalign)
  );

  // burst state, captured at launch
  logic [AW-1:0] addr_q;
  trans_e        trans_q;
  logic [CW-1:0] left_q;
  logic          undef_q, wrap_q, err_q;
  logic [2:0]    inc_q;
  logic [MW-1:0] mask_q;

  logic [AW-1:0] nxt_addr;
  logic          nxt_bnd;

  burst_step #(.AW(AW), .MW(MW), .BB(BB)) u_step (
    .addr(addr_q), .inc(inc_q), .wrap(wrap_q), .mask(mask_q),
    .next(nxt_addr), .bnd_hit(nxt_bnd)
  );

  logic busy, last_beat, accept;
  assign busy      = (trans_q != TR_IDLE);
  assign last_beat = undef_q ? stop_i : (left_q == CW'(1));
  assign accept    = busy && ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      trans_q <= TR_IDLE;
      left_q  <= '0;
      undef_q <= 1'b0;
      wrap_q  <= 1'b0;
      inc_q   <= '0;
      mask_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (busy) begin
        if (accept) begin
          if (last_beat) begin
            trans_q <= TR_IDLE;
          end else begin
            addr_q  <= nxt_addr;
            left_q  <= left_q - CW'(1);
            trans_q <= nxt_bnd ? TR_NSEQ : TR_SEQ;
          end
        end
      end else if (start_i) begin
        if (d_misalign) begin
          err_q <= 1'b1;
        end else begin
          addr_q  <= start_addr_i;
          trans_q <= TR_NSEQ;
          left_q  <= d_beats;
          undef_q <= d_undef;
          wrap_q  <= d_wrap;
          inc_q   <= d_inc;
          mask_q  <= d_mask;
        end
      end
    end
  end

  assign addr_o  = addr_q;
  assign trans_o = trans_q;
  assign done_o  = accept && last_beat;
  assign err_o   = err_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
`timescale 1ns/1ps
module burst_addr_gen_chk #(
  parameter int AW = 32,
  parameter int BB = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          ready_i,
  input logic [AW-1:0] addr_o,
  input logic [1:0]    trans_o,
  input logic          done_o,
  input logic          err_o
);
  p_hold_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (trans_o != 2'b00 && !ready_i) |=> ($stable(addr_o) && $stable(trans_o)));

  p_region_r3: assert property (@(posedge clk) disable iff (rst)
    (trans_o == 2'b11) |-> (addr_o[AW-1:BB] == $past(addr_o[AW-1:BB])));

  p_seq_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (trans_o == 2'b11) |-> ($past(trans_o) != 2'b00));

  p_first_nseq_r2: assert property (@(posedge clk) disable iff (rst)
    (trans_o != 2'b00 && $past(trans_o) == 2'b00) |-> (trans_o == 2'b10));

  p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (trans_o == 2'b00));

  p_done_accept_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ready_i && trans_o != 2'b00));

  p_done_ends_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (trans_o == 2'b00));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .BB(BB)) u_chk (
  .clk(clk), .rst(rst), .ready_i(ready_i), .addr_o(addr_o),
  .trans_o(trans_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [2:0]  kind_i = '0;
  logic        stop_i = 1'b0;
  logic        ready_i = 1'b0;
  logic [31:0] addr_o;
  logic [1:0]  trans_o;
  logic        done_o, err_o;

  burst_addr_gen dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .size_i(size_i), .kind_i(kind_i), .stop_i(stop_i), .ready_i(ready_i),
    .addr_o(addr_o), .trans_o(trans_o), .done_o(done_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference
  int unsigned m_addr = 0;
  int  m_trans = 0, m_left = 0, m_inc = 1, m_blk = 1, m_acc = 0;
  bit  m_undef = 0, m_wrap = 0, m_err = 0;

  function automatic bit m_last();
    return m_undef ? stop_i : (m_left == 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_trans = 0; m_left = 0; m_err = 0; m_acc = 0;
      m_undef = 0; m_wrap = 0;
    end else begin
      m_err = 0;
      if (m_trans != 0) begin
        if (ready_i) begin
          m_acc++;
          if (m_last()) m_trans = 0;
          else begin
            m_left--;
            if (m_wrap) begin
              int unsigned base;
              base   = m_addr - (m_addr % m_blk);
              m_addr = base + ((m_addr - base + m_inc) % m_blk);
              m_trans = 3;
            end else begin
              m_addr  = m_addr + m_inc;
              m_trans = ((m_addr % 1024) == 0) ? 2 : 3;
            end
          end
        end
      end else if (start_i) begin
        int beats;
        m_inc = (size_i == 0) ? 1 : (size_i == 1) ? 2 : (size_i == 2) ? 4 : 0;
        if (m_inc == 0 || (start_addr_i % m_inc) != 0) m_err = 1;
        else begin
          beats   = (kind_i >> 1) == 0 ? 1 : (2 << (kind_i >> 1));
          m_undef = (kind_i == 1);
          m_wrap  = (kind_i == 2 || kind_i == 4 || kind_i == 6);
          m_blk   = beats * m_inc;
          m_left  = beats;
          m_addr  = start_addr_i;
          m_trans = 2;
          m_acc   = 0;
        end
      end
    end
  end

  task automatic check(input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    check("addr", addr_o, m_addr);
    check("trans", trans_o, m_trans);
    check("done", done_o, (m_trans != 0 && ready_i && m_last()) ? 1 : 0);
    check("err", err_o, m_err);
  end

  function automatic logic pick(input int mode);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
  endfunction

  task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] kd,
                     input int stop_at, input int mode, input bit poke, input string req);
    int it = 0;
    @(negedge clk);
    cur_req = req;
    start_i = 1'b1; start_addr_i = a; size_i = sz; kind_i = kd;
    stop_i = 1'b0; ready_i = pick(mode);
    @(negedge clk);
    start_i = 1'b0;
    while (m_trans != 0) begin
      ready_i = pick(mode);
      stop_i  = (m_acc >= stop_at - 1);
      if (poke && it == 1) begin
        start_i = 1'b1; start_addr_i = 32'h800; size_i = 2'd0; kind_i = 3'd7;
      end else start_i = 1'b0;
      it++;
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0; ready_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    run(32'h13,  2'd0, 3'd0, 0, 0, 0, "R7 single");
    run(32'h100, 2'd2, 3'd3, 0, 0, 0, "R4 incr4 word");
    run(32'h108, 2'd2, 3'd2, 0, 0, 0, "R5 wrap4 word");
    run(32'h36,  2'd1, 3'd4, 0, 1, 0, "R5 wrap8 half");
    run(32'h3FB, 2'd0, 3'd6, 0, 1, 0, "R5 wrap16 byte");
    run(32'h3F8, 2'd1, 3'd7, 0, 0, 0, "R3 incr16 half boundary");
    run(32'h3F0, 2'd2, 3'd1, 9, 1, 0, "R3 undefined word boundary");
    run(32'h7FE, 2'd1, 3'd1, 3, 0, 0, "R7 undefined stop");
    run(32'h20,  2'd0, 3'd5, 0, 1, 0, "R6 incr8 waits");
    run(32'h40,  2'd2, 3'd5, 0, 1, 1, "R9 start while busy");
    run(32'h88,  2'd2, 3'd6, 0, 1, 1, "R9 wrap start while busy");
    run(32'h101, 2'd1, 3'd3, 0, 0, 0, "R10 half misaligned");
    run(32'h102, 2'd2, 3'd3, 0, 0, 0, "R10 word misaligned");
    run(32'h0,   2'd3, 3'd3, 0, 0, 0, "R10 size code 3");
    run(32'h10,  2'd0, 3'd3, 0, 1, 0, "R8 done with waits");
    run(32'h3FC, 2'd2, 3'd7, 0, 1, 0, "R2 incr16 start near line");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule